// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block collects 86 interrupt request lines and offers the core one of them at a time. Each line has a two-bit priority level, from 0 to 3, that software writes through a small register port. Lines 0 and 1 are wired to level 3, and writes cannot change them. A line is latched as pending on the rising edge of its request input, but only while its enable bit is set. Each level has its own priority encoder, and within a level the pending line with the smallest number is chosen. The highest level whose winner passes the core's two-bit mask then wins overall.

The grant goes to the core as a registered request. Beside it the block gives the source number, the level, and a vector address. The address is the base register with its low seven bits replaced by the source number, so each source gets its own slot in the vector table. The grant stays fixed until the core pulses acknowledge. Acknowledge clears that source's pending latch, and arbitration then starts again. The core allows nesting by raising its mask to one above the level it is serving, so only strictly higher levels can interrupt that handler.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, `req_o` is 0 and `vec_o`, `lvl_o` and `vaddr_o` are 0. Every programmable level reads 0, every enable reads 0 and the base register reads 0.
- R2: The level register at address k (k = 0 to 10) holds the level of source 8k+j in bits [2j+1:2j]. Writes to these registers read back. Bits that belong to no source read 0.
- R3: Sources 0 and 1 always have level 3. Their level bits read 3 and ignore writes.
- R4: The enable register at address 16+k holds the enable of source 16k+j in bit j, and bits with no source read 0. A rising edge on a disabled source is not latched: it never produces a request, even if the source is enabled later.
- R5: Among pending, enabled sources of the same level, the lowest source number is granted first.
- R6: Among the levels whose winners pass the mask, the higher level number wins.
- R7: A level L is accepted only when L >= `mask_i` (mask 0 accepts all levels, mask 3 accepts only level 3). When nothing is accepted, `req_o` stays 0.
- R8: The base register is at address 24. On a grant, `vaddr_o` = {base[15:7], source number}.
- R9: A rising edge on a request line is latched at the first clock edge and seen on `req_o` at the second. A line that stays high does not request again after it is acknowledged.
- R10: While `req_o` is 1 and `ack_i` is 0, `vec_o`, `lvl_o` and `vaddr_o` hold, even if a higher-priority source arrives. With `ack_i` high, `req_o` is 0 at the next edge, and the acknowledged source's pending latch is cleared.
- R11: While no request is raised, `vec_o` and `vaddr_o` keep their last granted values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| irq_i | input | 86 | Interrupt request lines, edge-captured |
| mask_i | input | 2 | Core's current priority mask |
| ack_i | input | 1 | Acknowledge pulse from the core |
| req_o | output | 1 | Registered interrupt request to the core |
| vec_o | output | 7 | Granted source number |
| lvl_o | output | 2 | Granted level |
| vaddr_o | output | 16 | Vector address |

## Verification
Four rules are checked on every cycle:
- the grant stays stable while it waits for acknowledge;
- acknowledge drops the request at the next edge;
- each new grant has a level the mask allowed one cycle earlier, and its address carries the upper bits of the base register;
- the vector does not move while the request is low.

The ordering rules are not checked on every cycle, and only the bench's scenarios show them:
- lowest index within a level;
- higher level across levels;
- fixed levels of sources 0 and 1;
- the enable gate on edge capture;
- no second request from a line that is held high.

For these, the bench raises every line at once and compares the whole grant sequence with one it computes itself.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 1 << LVL_W;

  typedef logic [LVL_W-1:0] lvl_t;

  // a level passes when it is at or above the core mask
  function automatic logic lvl_accepted(input lvl_t lvl, input lvl_t mask);
    return lvl >= mask;
  endfunction
endpackage

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs
  import lvl_irq_pkg::*;
#(
  parameter int   NUM_SRC   = 86,
  parameter int   DATA_W    = 16,
  parameter int   ADDR_W    = 5,
  parameter int   FIXED_CNT = 2,
  parameter lvl_t FIXED_LVL = 2'd3,
  parameter int   LVL_ADDR0 = 0,
  parameter int   EN_ADDR0  = 16,
  parameter int   BASE_ADDR = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  output lvl_t [NUM_SRC-1:0]      lvl,
  output logic [NUM_SRC-1:0]      en,
  output logic [DATA_W-1:0]       base
);
  localparam int SPW = DATA_W / LVL_W;

  logic [DATA_W-1:0] base_q, base_d;
  logic              base_hit;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int LWORD = s / SPW;
    localparam int LBIT  = (s % SPW) * LVL_W;
    localparam int EWORD = s / DATA_W;
    localparam int EBIT  = s % DATA_W;

    logic en_q, en_d, en_hit;
    assign en_hit = we && (addr == ADDR_W'(EN_ADDR0 + EWORD));

    always_comb en_d = en_hit ? wdata[EBIT] : en_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= en_d;
    end
    assign en[s] = en_q;

    if (s < FIXED_CNT) begin : g_fixed
      assign lvl[s] = FIXED_LVL;
    end else begin : g_prog
      lvl_t lvl_q, lvl_d;
      logic lvl_hit;
      assign lvl_hit = we && (addr == ADDR_W'(LVL_ADDR0 + LWORD));

      always_comb lvl_d = lvl_hit ? wdata[LBIT +: LVL_W] : lvl_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
      end
      assign lvl[s] = lvl_q;
    end
  end

  assign base_hit = we && (addr == ADDR_W'(BASE_ADDR));
  always_comb base_d = base_hit ? wdata : base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end
  assign base = base_q;

  always_comb begin
    rdata = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (addr == ADDR_W'(LVL_ADDR0 + s / SPW))
        rdata[(s % SPW) * LVL_W +: LVL_W] = lvl[s];
      if (addr == ADDR_W'(EN_ADDR0 + s / DATA_W))
        rdata[s % DATA_W] = en[s];
    end
    if (addr == ADDR_W'(BASE_ADDR))
      rdata = base_q;
  end
endmodule

// File: rtl/lvl_irq_pend.sv
module lvl_irq_pend #(
  parameter int NUM_SRC = 86,
  parameter int IDX_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq,
  input  logic [NUM_SRC-1:0] en,
  input  logic               clr_vld,
  input  logic [IDX_W-1:0]   clr_idx,
  output logic [NUM_SRC-1:0] pend
);
  logic [NUM_SRC-1:0] irq_q, pend_q, pend_d, clr_mask, rise;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++)
      clr_mask[i] = clr_vld && (clr_idx == IDX_W'(i));
    rise   = irq & ~irq_q & en;
    // a fresh edge outranks a clear in the same cycle
    pend_d = (pend_q & ~clr_mask) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= irq;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/lvl_irq_enc.sv
module lvl_irq_enc #(
  parameter int NUM_SRC = 86,
  parameter int IDX_W   = 7
) (
  input  logic [NUM_SRC-1:0] cand,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (cand[i]) idx = IDX_W'(i);
    found = |cand;
  end
endmodule

// File: rtl/lvl_irq_pick.sv
module lvl_irq_pick
  import lvl_irq_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic [NUM_LVL-1:0]            found,
  input  logic [NUM_LVL-1:0][IDX_W-1:0] idx,
  input  lvl_t                          mask,
  output logic                          win_vld,
  output lvl_t                          win_lvl,
  output logic [IDX_W-1:0]              win_idx
);
  always_comb begin
    win_vld = 1'b0;
    win_lvl = '0;
    win_idx = '0;
    // ascending scan: the last accepted level, i.e. the highest, wins
    for (int l = 0; l < NUM_LVL; l++) begin
      if (found[l] && lvl_accepted(lvl_t'(l), mask)) begin
        win_vld = 1'b1;
        win_lvl = lvl_t'(l);
        win_idx = idx[l];
      end
    end
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter  int NUM_SRC   = 86,
  parameter  int DATA_W    = 16,
  parameter  int ADDR_W    = 5,
  parameter  int FIXED_CNT = 2,
  localparam int IDX_W     = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic [1:0]         mask_i,
  input  logic               ack_i,
  output logic               req_o,
  output logic [IDX_W-1:0]   vec_o,
  output logic [1:0]         lvl_o,
  output logic [DATA_W-1:0]  vaddr_o
);
  // reset: asserted asynchronously, released on the second clock edge
  logic rst_meta, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_int_n <= rst_meta;
    end
  end

  lvl_t [NUM_SRC-1:0]            src_lvl;
  logic [NUM_SRC-1:0]            src_en, pend;
  logic [DATA_W-1:0]             base_w;
  logic [NUM_LVL-1:0][NUM_SRC-1:0] cand;
  logic [NUM_LVL-1:0]            found;
  logic [NUM_LVL-1:0][IDX_W-1:0] enc_idx;
  logic                          win_vld;
  lvl_t                          win_lvl;
  logic [IDX_W-1:0]              win_idx;

  logic              req_q, req_d, grant, ack_hit;
  logic [IDX_W-1:0]  vec_q, vec_d;
  lvl_t              lvl_q, lvl_d;
  logic [DATA_W-1:0] vaddr_q, vaddr_d;

  lvl_irq_regs #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIXED_CNT(FIXED_CNT)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .lvl(src_lvl), .en(src_en), .base(base_w)
  );

  lvl_irq_pend #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pend (
    .clk(clk), .rst_n(rst_int_n), .irq(irq_i), .en(src_en),
    .clr_vld(ack_hit), .clr_idx(vec_q), .pend(pend)
  );

  always_comb begin
    for (int l = 0; l < NUM_LVL; l++)
      for (int s = 0; s < NUM_SRC; s++)
        cand[l][s] = pend[s] && src_en[s] && (src_lvl[s] == lvl_t'(l));
  end

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    lvl_irq_enc #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_enc (
      .cand(cand[l]), .found(found[l]), .idx(enc_idx[l])
    );
  end

  lvl_irq_pick #(.IDX_W(IDX_W)) u_pick (
    .found(found), .idx(enc_idx), .mask(mask_i),
    .win_vld(win_vld), .win_lvl(win_lvl), .win_idx(win_idx)
  );

  always_comb begin
    ack_hit = req_q && ack_i;
    grant   = !req_q && win_vld;
    req_d   = req_q ? !ack_i : win_vld;
    vec_d   = grant ? win_idx : vec_q;
    lvl_d   = grant ? win_lvl : lvl_q;
    vaddr_d = grant ? {base_w[DATA_W-1:IDX_W], win_idx} : vaddr_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      req_q   <= 1'b0;
      vec_q   <= '0;
      lvl_q   <= '0;
      vaddr_q <= '0;
    end else begin
      req_q   <= req_d;
      vec_q   <= vec_d;
      lvl_q   <= lvl_d;
      vaddr_q <= vaddr_d;
    end
  end

  assign req_o   = req_q;
  assign vec_o   = vec_q;
  assign lvl_o   = lvl_q;
  assign vaddr_o = vaddr_q;
endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
module lvl_irq_ctrl_chk #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack_i,
  input logic [1:0]        mask_i,
  input logic              req_o,
  input logic [IDX_W-1:0]  vec_o,
  input logic [1:0]        lvl_o,
  input logic [DATA_W-1:0] vaddr_o,
  input logic [DATA_W-1:0] base
);
  localparam logic [DATA_W-1:0] HI_MASK = {{(DATA_W-IDX_W){1'b1}}, {IDX_W{1'b0}}};

  // R10: an unacknowledged grant is held unchanged
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o && $stable(vec_o) && $stable(lvl_o) && $stable(vaddr_o)));

  // R10: acknowledge removes the request on the next edge
  assert_ack_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && ack_i) |=> !req_o);

  // R7: a new grant carries a level the mask allowed one cycle before
  assert_mask_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> (lvl_o >= $past(mask_i)));

  // R8: the upper address bits come from the base register
  assert_base_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> ((vaddr_o & HI_MASK) == ($past(base) & HI_MASK)));

  // R11: the vector moves only on a fresh grant
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o |=> (req_o || ($stable(vec_o) && $stable(vaddr_o))));
endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .mask_i(mask_i), .req_o(req_o),
  .vec_o(vec_o), .lvl_o(lvl_o), .vaddr_o(vaddr_o), .base(base_w)
);

// File: tb/lvl_irq_ctrl_tb_top.sv
module lvl_irq_ctrl_tb_top;
  localparam int NSRC = 86;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [NSRC-1:0] irq;
  logic [1:0]  mask;
  logic        ack;
  logic        req;
  logic [6:0]  vec;
  logic [1:0]  lvl;
  logic [15:0] vaddr;

  int checks = 0;
  int fails  = 0;
  logic [15:0] base_exp = 16'h0000;

  always #2 clk = ~clk;   // 250 MHz

  lvl_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_i(irq), .mask_i(mask),
    .ack_i(ack), .req_o(req), .vec_o(vec), .lvl_o(lvl), .vaddr_o(vaddr)
  );

  function automatic logic [1:0] lvl_of(input int s);
    return (s < 2) ? 2'd3 : 2'((s / 3) % 4);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // expected read of a level word when the programmable sources hold pat
  function automatic logic [15:0] lvl_word(input int k, input logic [15:0] pat);
    logic [15:0] w = '0;
    for (int j = 0; j < 8; j++) begin
      int s = 8 * k + j;
      if (s < 2)         w[2*j +: 2] = 2'd3;
      else if (s < NSRC) w[2*j +: 2] = pat[2*j +: 2];
    end
    return w;
  endfunction

  function automatic logic [15:0] en_word(input int k, input logic [15:0] pat);
    logic [15:0] w = '0;
    for (int j = 0; j < 16; j++)
      if (16 * k + j < NSRC) w[j] = pat[j];
    return w;
  endfunction

  function automatic logic [15:0] lvl_cfg(input int k);
    logic [15:0] w = '0;
    for (int j = 0; j < 8; j++)
      if (8 * k + j < NSRC) w[2*j +: 2] = lvl_of(8 * k + j);
    return w;
  endfunction

  task automatic chk_grant(input int s, input string tag);
    logic [31:0] e, a;
    e = {6'd0, 1'b1, lvl_of(s), 7'(s), (base_exp & 16'hFF80) | 16'(s)};
    a = {6'd0, req, lvl, vec, vaddr};
    chk(a == e, tag, a, e);
  endtask

  task automatic ack_cycle(input string tag);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(req == 1'b0, tag, 32'(req), 32'd0);
    @(negedge clk);
  endtask

  task automatic serve(input int hi, input int lo, output int last);
    last = 0;
    for (int l = hi; l >= lo; l--)
      for (int s = 0; s < NSRC; s++)
        if (int'(lvl_of(s)) == l) begin
          chk_grant(s, "R5/R6 order");
          ack_cycle("R10 ack");
          last = s;
        end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d;
    int last;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    irq = '0; mask = 2'd0; ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk({req, lvl, vec, vaddr} == '0, "R1 outputs", 32'({req, lvl, vec, vaddr}), 32'd0);
    for (int k = 0; k < 11; k++) begin
      rd(5'(k), d);
      chk(d == lvl_word(k, 16'h0000), "R1 level reset", 32'(d), 32'(lvl_word(k, 16'h0000)));
    end
    for (int k = 0; k < 6; k++) begin
      rd(5'(16 + k), d);
      chk(d == 16'h0, "R1 enable reset", 32'(d), 32'd0);
    end
    rd(5'd24, d);
    chk(d == 16'h0, "R1 base reset", 32'(d), 32'd0);

    // R2 / R3 level packing and fixed sources
    for (int k = 0; k < 11; k++) begin
      logic [15:0] p = 16'h9C63 ^ 16'(k * 16'h1111);
      wr(5'(k), p);
      rd(5'(k), d);
      chk(d == lvl_word(k, p), "R2 level readback", 32'(d), 32'(lvl_word(k, p)));
    end
    wr(5'd0, 16'h0000);
    rd(5'd0, d);
    chk(d == 16'h000F, "R3 fixed ignores write", 32'(d), 32'h000F);

    // R4 enable packing
    for (int k = 0; k < 6; k++) begin
      logic [15:0] p = 16'hA5A5 ^ 16'(k * 16'h0F1E);
      wr(5'(16 + k), p);
      rd(5'(16 + k), d);
      chk(d == en_word(k, p), "R4 enable readback", 32'(d), 32'(en_word(k, p)));
    end
    for (int k = 0; k < 6; k++) wr(5'(16 + k), 16'h0000);

    // R4 edge on a disabled source is dropped
    irq[40] = 1'b1;
    repeat (3) @(negedge clk);
    chk(req == 1'b0, "R4 disabled no req", 32'(req), 32'd0);
    irq[40] = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 6; k++) wr(5'(16 + k), 16'hFFFF);
    repeat (3) @(negedge clk);
    chk(req == 1'b0, "R4 no late capture", 32'(req), 32'd0);

    // configure levels and base
    for (int k = 0; k < 11; k++) wr(5'(k), lvl_cfg(k));
    base_exp = 16'h1234;
    wr(5'd24, base_exp);
    rd(5'd24, d);
    chk(d == base_exp, "R8 base readback", 32'(d), 32'(base_exp));

    // single-source sweep: R9 latency, R8 address
    for (int s = 0; s < NSRC; s++) begin
      irq[s] = 1'b1;
      @(negedge clk);
      if (s == 5) chk(req == 1'b0, "R9 one-edge latency", 32'(req), 32'd0);
      @(negedge clk);
      chk_grant(s, "R8/R9 single");
      irq[s] = 1'b0;
      ack_cycle("R10 single ack");
    end

    // all lines at once, mask 2: levels 3 then 2
    mask = 2'd2;
    irq = '1;
    repeat (2) @(negedge clk);
    serve(3, 2, last);
    chk(req == 1'b0, "R7 masked idle", 32'(req), 32'd0);
    repeat (3) @(negedge clk);
    chk({req, vec} == {1'b0, 7'(last)}, "R11 vec holds", 32'({req, vec}), 32'(last));
    mask = 2'd3;
    repeat (2) @(negedge clk);
    chk(req == 1'b0, "R7 mask 3 idle", 32'(req), 32'd0);
    mask = 2'd0;
    @(negedge clk);
    serve(1, 0, last);
    repeat (3) @(negedge clk);
    chk(req == 1'b0, "R9 held lines no re-request", 32'(req), 32'd0);
    irq = '0;
    @(negedge clk);

    // R10 grant held while a higher source arrives
    irq[50] = 1'b1;
    repeat (2) @(negedge clk);
    chk_grant(50, "R10 first grant");
    irq[0] = 1'b1;
    repeat (3) @(negedge clk);
    chk_grant(50, "R10 held grant");
    irq[50] = 1'b0;
    ack_cycle("R10 ack");
    chk_grant(0, "R6 preempt after ack");
    ack_cycle("R10 ack 2");
    repeat (2) @(negedge clk);
    chk(req == 1'b0, "R9 held high no repeat", 32'(req), 32'd0);
    irq[0] = 1'b0;
    @(negedge clk);
    irq[0] = 1'b1;
    repeat (2) @(negedge clk);
    chk_grant(0, "R9 new edge");
    irq[0] = 1'b0;
    ack_cycle("R10 ack 3");

    // R8 with a different base
    base_exp = 16'hABCD;
    wr(5'd24, base_exp);
    irq[20] = 1'b1;
    repeat (2) @(negedge clk);
    chk_grant(20, "R8 new base");
    chk(vaddr == 16'hAB94, "R8 address value", 32'(vaddr), 32'hAB94);
    irq[20] = 1'b0;
    ack_cycle("R10 ack 4");

    summary();
    $finish;
  end
endmodule